// File: doc/BRIEF.md
# Display Power and Clock Sequencer

This block is the control sequencer of a two-channel display controller. Software drives it through a small register bus. Through that bus it can:

- issue a self-clearing soft reset;
- enable each channel;
- set one global run bit.

When the run bit rises, every enabled channel is walked up through a power ramp. When the run bit falls, every enabled channel is walked back down. Each ramp step lasts a programmable number of cycles.

When a power-down completes, the sequencer stops the dot clock by itself. Software restarts the clock by clearing the stop register, and sees it running once the register reads back 0. The block also holds the clock-source select and one divider field per channel, and presents them on output pins. The divider itself and the power rails are outside this block.

A status word reports each channel's power level, a done flag and a stop-pending flag. A driver polls this word to learn when a start or a stop has finished.

Top module: `dps_seq`

## Requirements
- R1: Writing 1 to bit 8 of the control register (address 0) starts a soft reset. The reset clears the run and enable bits and forces every channel's power level to 0. Bit 8 reads 1 for RST_CYC cycles and then clears itself. Control writes that arrive while bit 8 reads 1 are ignored.
- R2: In the control register, bit 0 is the run bit, bit 1 enables the main channel and bit 2 enables the secondary channel. All three read back as written.
- R3: While the run bit is 1, an enabled channel's 2-bit power level steps 0, then 1, then 3. Each step lasts as many cycles as the step register (address 4, reset value 2) holds; a value of 0 counts as 1.
- R4: While the run bit is 0, an enabled channel's level steps 3, then 1, then 0, with the same step length.
- R5: A channel whose enable bit is 0 keeps its power level unchanged.
- R6: The done flag (status bit 16, pin seq_done) is 1 one cycle after every enabled channel sits at the target level: 3 when running, 0 when not. With no channel enabled it is 1.
- R7: A control write that clears a set run bit raises stop-pending (status bit 17). Once every enabled channel reads 0, stop-pending drops and the dot-clock stop register (address 2, bit 0) is set to 1 on its own.
- R8: The dot-clock stop register resets to 1. Writing 0 while it reads 1 restarts the clock, and it then reads 0 after RESTART_CYC cycles. Writing 1 stops the clock at once.
- R9: dclk_gate[k] is 1 exactly one cycle after the dot clock is running and channel k is enabled.
- R10: Bits 17:16 of the clock register (address 1) select the clock source: 0 bus clock, 1 peripheral clock, 2 external clock. A write of 3 leaves the previous source in place. The selection drives clk_src.
- R11: The divider fields sit at bits 7:0 (main) and 15:8 (secondary) of the clock register. A written value of 1 is stored as 0x40 (bit 6, divide by one); any other value is stored as written. The fields drive clk_div.
- R12: rd_data returns, one cycle after reg_addr is presented, the register at that address. At address 3 the status word places channel k's level at bits 2k+1:2k. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for write and read |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data |
| pwr_state | output | 2*N_CH | Power level per channel, 2 bits each |
| dclk_gate | output | N_CH | Dot-clock gate per channel |
| clk_div | output | DIV_W*N_CH | Divider field per channel |
| clk_src | output | 2 | Clock-source select |
| seq_done | output | 1 | All enabled channels at target level |

## Verification
The power ramp is tried in four ways:

- both channels rising together;
- the main channel falling alone while the secondary channel is disabled at full level;
- a rise with a step length of 0;
- a run and stop with no channel enabled.

The first two show whether the step order and dwell time are right in each direction and whether disabled channels are left alone. The last two probe the degenerate step length and the empty handshake that must still stop the dot clock. Reset writes landing while a reset is busy, the reserved clock-source code and the divide-by-one remap are each tried against a neighbouring ordinary write, so a dropped or misplaced field shows as a wrong read-back.

// File: rtl/dps_pkg.sv
package dps_pkg;
  // register addresses
  localparam int A_CTRL = 0;
  localparam int A_CLK  = 1;
  localparam int A_DCK  = 2;
  localparam int A_STAT = 3;
  localparam int A_STEP = 4;
  // bit positions decoded by software
  localparam int B_RUN   = 0;
  localparam int B_RESET = 8;
  localparam int B_SRC   = 16;
  localparam int B_DONE  = 16;
  localparam int B_PEND  = 17;
  // power levels
  localparam logic [1:0] LVL_OFF  = 2'd0;
  localparam logic [1:0] LVL_MID  = 2'd1;
  localparam logic [1:0] LVL_FULL = 2'd3;
  localparam logic [1:0] SRC_RSVD = 2'd3;

  function automatic logic [1:0] lvl_next(input logic [1:0] cur, input logic up);
    if (up) return (cur == LVL_OFF) ? LVL_MID : LVL_FULL;
    else    return (cur == LVL_FULL) ? LVL_MID : LVL_OFF;
  endfunction
endpackage

// File: rtl/dps_soft_rst.sv
module dps_soft_rst #(
  parameter int RST_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic trigger,
  output logic busy
);
  localparam int CW = $clog2(RST_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else if (trigger) begin
      busy <= 1'b1;
      cnt  <= '0;
    end
  end

  // R1
  rst_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cnt <= LAST));
endmodule

// File: rtl/dps_chan_pwr.sv
module dps_chan_pwr import dps_pkg::*; #(
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              enable,
  input  logic              go_up,
  input  logic [STEP_W-1:0] step_len,
  output logic [1:0]        level
);
  logic [STEP_W-1:0] cnt;
  logic [STEP_W-1:0] last;
  logic              moving;

  assign last   = (step_len == '0) ? '0 : step_len - STEP_W'(1);
  assign moving = enable && (go_up ? (level != LVL_FULL) : (level != LVL_OFF));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      level <= LVL_OFF;
      cnt   <= '0;
    end else if (moving) begin
      if (cnt >= last) begin
        cnt   <= '0;
        level <= lvl_next(level, go_up);
      end else begin
        cnt <= cnt + STEP_W'(1);
      end
    end else begin
      cnt <= '0;
    end
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && !enable) |=> $stable(level));
  // R3
  full_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && enable && go_up && level == LVL_FULL) |=> (level == LVL_FULL));
  // R4
  no_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && level == LVL_OFF) |=> (level != LVL_FULL));
endmodule

// File: rtl/dps_dclk_ctl.sv
module dps_dclk_ctl #(
  parameter int RESTART_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic force_stop,
  input  logic wr_stop,
  input  logic wr_val,
  output logic stopped,
  output logic restarting
);
  localparam int CW = $clog2(RESTART_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(RESTART_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      stopped    <= 1'b1;
      restarting <= 1'b0;
      cnt        <= '0;
    end else if (force_stop || (wr_stop && wr_val)) begin
      stopped    <= 1'b1;
      restarting <= 1'b0;
      cnt        <= '0;
    end else if (restarting) begin
      if (cnt == LAST) begin
        stopped    <= 1'b0;
        restarting <= 1'b0;
        cnt        <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else if (wr_stop && !wr_val && stopped) begin
      restarting <= 1'b1;
      cnt        <= '0;
    end
  end

  // R8
  restart_path_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stopped) |-> $past(restarting));
endmodule

// File: rtl/dps_seq.sv
module dps_seq import dps_pkg::*; #(
  parameter int N_CH        = 2,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int DIV_W       = 8,
  parameter int STEP_W      = 8,
  parameter int STEP_RST    = 2,
  parameter int RST_CYC     = 4,
  parameter int RESTART_CYC = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [DATA_W-1:0]     rd_data,
  output logic [2*N_CH-1:0]     pwr_state,
  output logic [N_CH-1:0]       dclk_gate,
  output logic [DIV_W*N_CH-1:0] clk_div,
  output logic [1:0]            clk_src,
  output logic                  seq_done
);
  localparam logic [DIV_W-1:0] DIV1_CODE = DIV_W'(1 << 6);
  localparam logic [DIV_W-1:0] DIV_ONE   = DIV_W'(1);

  function automatic logic [DIV_W-1:0] div_code(input logic [DIV_W-1:0] f);
    return (f == DIV_ONE) ? DIV1_CODE : f;
  endfunction

  logic wr_ctrl, wr_clk, wr_dck, wr_step;
  assign wr_ctrl = wr_en && (reg_addr == ADDR_W'(A_CTRL));
  assign wr_clk  = wr_en && (reg_addr == ADDR_W'(A_CLK));
  assign wr_dck  = wr_en && (reg_addr == ADDR_W'(A_DCK));
  assign wr_step = wr_en && (reg_addr == ADDR_W'(A_STEP));

  // soft reset
  logic rst_busy, rst_go;
  assign rst_go = wr_ctrl && wr_data[B_RESET] && !rst_busy;

  dps_soft_rst #(.RST_CYC(RST_CYC)) u_srst (
    .clk(clk), .rst(rst), .trigger(rst_go), .busy(rst_busy)
  );

  // control register
  logic            ctrl_run;
  logic [N_CH-1:0] ctrl_en;

  always_ff @(posedge clk) begin
    if (rst || rst_go) begin
      ctrl_run <= 1'b0;
      ctrl_en  <= '0;
    end else if (wr_ctrl && !rst_busy) begin
      ctrl_run <= wr_data[B_RUN];
      ctrl_en  <= wr_data[N_CH:1];
    end
  end

  // step length
  logic [STEP_W-1:0] step_q;
  always_ff @(posedge clk) begin
    if (rst)          step_q <= STEP_W'(STEP_RST);
    else if (wr_step) step_q <= wr_data[STEP_W-1:0];
  end

  // per-channel power ramps
  logic [1:0]      lvl [N_CH];
  logic [N_CH-1:0] ch_off, ch_hit;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    dps_chan_pwr #(.STEP_W(STEP_W)) u_pwr (
      .clk(clk), .rst(rst), .clear(rst_busy), .enable(ctrl_en[k]),
      .go_up(ctrl_run), .step_len(step_q), .level(lvl[k])
    );
    assign ch_off[k] = !ctrl_en[k] || (lvl[k] == LVL_OFF);
    assign ch_hit[k] = !ctrl_en[k] || (lvl[k] == (ctrl_run ? LVL_FULL : LVL_OFF));
    assign pwr_state[2*k +: 2] = lvl[k];
  end

  // stop handshake
  logic stop_pend, stop_fire, done_q;
  assign stop_fire = stop_pend && (&ch_off) && !rst_busy && !wr_ctrl;

  always_ff @(posedge clk) begin
    if (rst || rst_busy || rst_go) begin
      stop_pend <= 1'b0;
    end else if (wr_ctrl) begin
      if (wr_data[B_RUN])  stop_pend <= 1'b0;
      else if (ctrl_run)   stop_pend <= 1'b1;
    end else if (stop_fire) begin
      stop_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= &ch_hit;
  end
  assign seq_done = done_q;

  // dot clock
  logic dck_stopped, dck_restarting;
  dps_dclk_ctl #(.RESTART_CYC(RESTART_CYC)) u_dclk (
    .clk(clk), .rst(rst), .force_stop(stop_fire), .wr_stop(wr_dck),
    .wr_val(wr_data[0]), .stopped(dck_stopped), .restarting(dck_restarting)
  );

  logic [N_CH-1:0] gate_q;
  always_ff @(posedge clk) begin
    if (rst) gate_q <= '0;
    else     gate_q <= dck_stopped ? '0 : ctrl_en;
  end
  assign dclk_gate = gate_q;

  // clock configuration
  logic [DIV_W-1:0] div_q [N_CH];
  logic [1:0]       src_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_CH; k++) div_q[k] <= '0;
      src_q <= 2'd0;
    end else if (wr_clk) begin
      for (int k = 0; k < N_CH; k++) div_q[k] <= div_code(wr_data[k*DIV_W +: DIV_W]);
      if (wr_data[B_SRC +: 2] != SRC_RSVD) src_q <= wr_data[B_SRC +: 2];
    end
  end
  assign clk_src = src_q;

  always_comb begin
    for (int k = 0; k < N_CH; k++) clk_div[k*DIV_W +: DIV_W] = div_q[k];
  end

  // read path
  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (reg_addr == ADDR_W'(A_CTRL)) begin
      rd_word[B_RUN]   = ctrl_run;
      rd_word[N_CH:1]  = ctrl_en;
      rd_word[B_RESET] = rst_busy;
    end else if (reg_addr == ADDR_W'(A_CLK)) begin
      for (int k = 0; k < N_CH; k++) rd_word[k*DIV_W +: DIV_W] = div_q[k];
      rd_word[B_SRC +: 2] = src_q;
    end else if (reg_addr == ADDR_W'(A_DCK)) begin
      rd_word[0] = dck_stopped;
    end else if (reg_addr == ADDR_W'(A_STAT)) begin
      for (int k = 0; k < N_CH; k++) rd_word[2*k +: 2] = lvl[k];
      rd_word[B_DONE] = done_q;
      rd_word[B_PEND] = stop_pend;
    end else if (reg_addr == ADDR_W'(A_STEP)) begin
      rd_word[STEP_W-1:0] = step_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_word;
  end

  // R1
  busy_clears_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    rst_busy |-> (!ctrl_run && ctrl_en == '0));
  // R7
  auto_stop_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(stop_pend) && !$past(rst_busy) && !$past(wr_ctrl) && !$past(rst_go)) |-> dck_stopped);
  // R9
  gate_needs_clock_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_q != '0) |-> !$past(dck_stopped));
  // R6
  pend_not_done_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_pend && !(&ch_off)) |=> !done_q || ctrl_run || rst_busy);
endmodule

// File: tb/dps_seq_test.sv
module dps_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  pwr_state;
  logic [1:0]  dclk_gate;
  logic [15:0] clk_div;
  logic [1:0]  clk_src;
  logic        seq_done;

  always #5 clk = ~clk;

  dps_seq uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .pwr_state(pwr_state), .dclk_gate(dclk_gate),
    .clk_div(clk_div), .clk_src(clk_src), .seq_done(seq_done)
  );

  int checks = 0;
  int fails  = 0;
  bit cmp_on = 0;
  bit ended  = 0;

  // behavioural reference model
  int m_run, m_busy, m_bcnt, m_pend, m_done, m_dck, m_rp, m_rcnt, m_src, m_step;
  int m_en[2], m_lv[2], m_cnt[2], m_div[2], m_gate[2];
  int m_rd;

  always @(posedge clk) begin
    int wc, wk, wclk, wst, rgo, alloff, allhit, tgt, fire, eff, f;
    if (rst) begin
      m_run = 0; m_busy = 0; m_bcnt = 0; m_pend = 0; m_done = 0;
      m_dck = 1; m_rp = 0; m_rcnt = 0; m_src = 0; m_step = 2; m_rd = 0;
      for (int k = 0; k < 2; k++) begin
        m_en[k] = 0; m_lv[k] = 0; m_cnt[k] = 0; m_div[k] = 0; m_gate[k] = 0;
      end
    end else begin
      wc   = (wr_en && reg_addr == 0);
      wclk = (wr_en && reg_addr == 1);
      wk   = (wr_en && reg_addr == 2);
      wst  = (wr_en && reg_addr == 4);
      rgo  = (!m_busy && wc && wr_data[8]);
      tgt  = m_run ? 3 : 0;
      alloff = 1; allhit = 1;
      for (int k = 0; k < 2; k++) begin
        if (m_en[k] && m_lv[k] != 0)   alloff = 0;
        if (m_en[k] && m_lv[k] != tgt) allhit = 0;
      end
      fire = (!m_busy && !wc && m_pend && alloff);
      case (reg_addr)
        0: m_rd = m_run | (m_en[0] << 1) | (m_en[1] << 2) | (m_busy << 8);
        1: m_rd = m_div[0] | (m_div[1] << 8) | (m_src << 16);
        2: m_rd = m_dck;
        3: m_rd = m_lv[0] | (m_lv[1] << 2) | (m_done << 16) | (m_pend << 17);
        4: m_rd = m_step;
        default: m_rd = 0;
      endcase
      m_done = allhit;
      for (int k = 0; k < 2; k++) m_gate[k] = (!m_dck && m_en[k]) ? 1 : 0;
      eff = (m_step == 0) ? 1 : m_step;
      for (int k = 0; k < 2; k++) begin
        if (m_busy) begin
          m_lv[k] = 0; m_cnt[k] = 0;
        end else if (m_en[k] && m_lv[k] != tgt) begin
          if (m_cnt[k] >= eff - 1) begin
            m_cnt[k] = 0;
            if (m_run) m_lv[k] = (m_lv[k] == 0) ? 1 : 3;
            else       m_lv[k] = (m_lv[k] == 3) ? 1 : 0;
          end else m_cnt[k]++;
        end else m_cnt[k] = 0;
      end
      if (m_busy || rgo) m_pend = 0;
      else if (wc) begin
        if (wr_data[0]) m_pend = 0;
        else if (m_run) m_pend = 1;
      end else if (fire) m_pend = 0;
      if (fire || (wk && wr_data[0])) begin
        m_dck = 1; m_rp = 0; m_rcnt = 0;
      end else if (wk && !wr_data[0] && m_dck && !m_rp) begin
        m_rp = 1; m_rcnt = 0;
      end else if (m_rp) begin
        if (m_rcnt == 2) begin m_dck = 0; m_rp = 0; m_rcnt = 0; end
        else m_rcnt++;
      end
      if (rgo) begin
        m_run = 0; m_en[0] = 0; m_en[1] = 0;
      end else if (wc && !m_busy) begin
        m_run = wr_data[0]; m_en[0] = wr_data[1]; m_en[1] = wr_data[2];
      end
      if (m_busy) begin
        if (m_bcnt == 3) begin m_busy = 0; m_bcnt = 0; end
        else m_bcnt++;
      end else if (rgo) begin
        m_busy = 1; m_bcnt = 0;
      end
      if (wclk) begin
        for (int k = 0; k < 2; k++) begin
          f = wr_data[k*8 +: 8];
          m_div[k] = (f == 1) ? 8'h40 : f;
        end
        if (wr_data[17:16] != 2'd3) m_src = wr_data[17:16];
      end
      if (wst) m_step = wr_data[7:0];
    end
  end

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (cmp_on && !ended) begin
      chk("R3 pwr_state", pwr_state, {m_lv[1][1:0], m_lv[0][1:0]});
      chk("R6 seq_done", seq_done, m_done);
      chk("R9 dclk_gate", dclk_gate, {m_gate[1][0], m_gate[0][0]});
      chk("R11 clk_div", clk_div, {m_div[1][7:0], m_div[0][7:0]});
      chk("R10 clk_src", clk_src, m_src);
      chk("R12 rd_data", rd_data, m_rd);
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog got %0d expected below 50000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    wr_en = 1'b0; reg_addr = 3'(a);
    @(negedge clk);
    chk(tag, rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // follow the main channel's level until it reaches the target
  task automatic trace_main(input int target, input int v0, input int v1, input int v2,
                            input int dwell, input string tag);
    int seen[4];
    int n = 1;
    int mid = 0;
    seen[0] = pwr_state[1:0];
    for (int i = 0; i < 200 && pwr_state[1:0] != 2'(target); i++) begin
      @(negedge clk);
      if (pwr_state[1:0] == 2'd1) mid++;
      if (pwr_state[1:0] != 2'(seen[n-1]) && n < 4) begin
        seen[n] = pwr_state[1:0];
        n++;
      end
    end
    chk({tag, " order length"}, n, 3);
    chk({tag, " first level"}, seen[0], v0);
    chk({tag, " middle level"}, seen[1], v1);
    chk({tag, " final level"}, seen[2], v2);
    chk({tag, " dwell at level 1"}, mid, dwell);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1;
    // reset state
    rdchk(0, 32'h0, "R2 control after reset");
    rdchk(3, 32'h0001_0000, "R6 status after reset");
    rdchk(2, 32'h1, "R8 dot clock stopped after reset");
    rdchk(4, 32'h2, "R3 step reset value");
    // clock configuration
    wr(1, 32'h0002_0501);
    rdchk(1, 32'h0002_0540, "R11 divide-by-one remap on main");
    chk("R10 external source", clk_src, 2);
    wr(1, 32'h0003_0110);
    rdchk(1, 32'h0002_4010, "R10 reserved source ignored, R11 sub remap");
    chk("R11 clk_div pins", clk_div, 16'h4010);
    // dot clock restart
    wr(2, 32'h0);
    rdchk(2, 32'h1, "R8 still stopped during restart");
    idle(4);
    rdchk(2, 32'h0, "R8 running after restart");
    // power up both channels
    wr(4, 32'd5);
    wr(0, 32'h7);
    trace_main(3, 0, 1, 3, 5, "R3 rise");
    idle(2);
    rdchk(3, 32'h0001_000F, "R6 both full and done");
    chk("R9 both gates on", dclk_gate, 2'b11);
    rdchk(0, 32'h7, "R2 control readback");
    // stop with secondary disabled
    wr(0, 32'h2);
    rdchk(3, 32'h0002_000F, "R7 stop pending raised");
    trace_main(0, 3, 1, 0, 5, "R4 fall");
    idle(3);
    rdchk(3, 32'h0001_000C, "R5 disabled channel held at 3");
    rdchk(2, 32'h1, "R7 dot clock stopped automatically");
    chk("R9 gates off", dclk_gate, 2'b00);
    // soft reset
    wr(2, 32'h0);
    idle(5);
    wr(0, 32'h7);
    idle(40);
    rdchk(3, 32'h0001_000F, "R3 both full before reset");
    wr(0, 32'h100);
    rdchk(0, 32'h100, "R1 reset bit reads 1 while busy");
    wr(0, 32'h7);
    idle(6);
    rdchk(0, 32'h0, "R1 reset cleared and busy write ignored");
    rdchk(3, 32'h0001_0000, "R1 levels forced to 0");
    chk("R1 pwr_state pins", pwr_state, 4'h0);
    // step length of zero
    wr(4, 32'd0);
    wr(0, 32'h3);
    trace_main(3, 0, 1, 3, 1, "R3 zero step");
    // empty handshake still stops the clock
    wr(0, 32'h1);
    idle(2);
    rdchk(2, 32'h0, "R8 clock running before empty stop");
    wr(0, 32'h0);
    idle(3);
    rdchk(2, 32'h1, "R7 empty stop sets dot-clock stop");
    rdchk(3, 32'h0001_0003, "R5 R6 main held at 3 while disabled");
    rdchk(6, 32'h0, "R12 unmapped address");
    idle(2);
    ended = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule